// File: doc/BRIEF.md
# Two-Channel Bus Selector with Serial Control

This block is a synchronous two-wire serial slave that owns a small control register and uses it to pick which of two downstream bus pairs is connected. It oversamples the serial clock and data lines on the system clock, finds start and stop conditions, matches its own 7-bit address (a fixed 4-bit prefix followed by three strap inputs), acknowledges, and either stores written control bytes or returns a status byte.

The connection itself is handled outside: the block only drives two one-hot channel enables and the pull-down enable for the data line. A newly written selection is held back until the stop condition that closes the transfer, so the downstream pair is never switched mid-transfer. Two live interrupt levels from the downstream sides are folded into the byte returned on a read.

Top module: `chan_mux_ctrl`

## Requirements
- R1: The block answers only to address `{ADDR_PREFIX, strap_i}` (default prefix 4'b1110) followed by a direction bit, where 1 means read and 0 means write; a matching address is acknowledged by pulling the data line low during the ninth clock.
- R2: In a write, every data byte after the address is acknowledged and the register keeps only the last byte received; the stored bits change only while the acknowledge is being driven.
- R3: The selection decodes control bits 2:0: 100 enables channel 0 (`ch_en_o` = 2'b01), 101 enables channel 1 (`ch_en_o` = 2'b10), and any value with bit 2 clear or with bits 2:1 = 11 enables no channel; at most one enable is ever high.
- R4: A written selection reaches `ch_en_o` only after the stop condition that ends the transfer; before that the previous selection stays in force.
- R5: A read returns bits 7:6 as 0, bit 5 as `irq_i[1]`, bit 4 as `irq_i[0]` and bits 3:0 as the stored values; the interrupt levels are captured when each read byte is loaded, at the end of the preceding acknowledge.
- R6: After reset the register is zero, no channel is enabled and the data line is released.
- R7: When the address does not match, the block leaves the data line released until the next start or stop and changes neither the register nor the selection.
- R8: When the master answers a read byte with no-acknowledge, the block releases the data line and keeps it released so the master can issue a stop; any stop also releases the line.
- R9: A start (data falling while clock is high) seen in the middle of any byte aborts the transfer, discards the partial byte and begins a new address match; a stop is data rising while clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| strap_i | input | 3 | Low three address bits |
| irq_i | input | 2 | Active-high interrupt levels, bit n for channel n |
| ch_en_o | output | 2 | One-hot channel enables, bit n for channel n |
| sda_pull_o | output | 1 | When high, the data line is pulled low |

## Verification
Each line passes two synchronizer flops and one edge register, so the data pull-down changes three clock cycles after the serial clock falls and the channel enables change three cycles after the data line rises in a stop. The bench master holds every quarter of a bit for six clocks and samples the acknowledge and read data in the middle of the clock-high phase, and it samples the enables one quarter-bit after a stop, always on a falling system-clock edge. Channel checks are also taken between the last acknowledge and the stop to show that the old selection still holds.

// File: rtl/chan_mux_ctrl.sv
module chan_mux_ctrl #(
  parameter logic [3:0] ADDR_PREFIX = 4'b1110
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic [1:0] irq_i,
  output logic [1:0] ch_en_o,
  output logic       sda_pull_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_SKIP
  } st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       scl_q, sda_q;
  logic       start_det, stop_det, scl_rise, scl_fall;

  st_t        state;
  logic [2:0] cnt;
  logic       done;
  logic [7:0] sh;
  logic [6:0] tx;
  logic       rw;
  logic       nack;
  logic [3:0] ctrl_q;
  logic [1:0] sel_q;
  logic       pull;
  logic [7:0] rbyte;
  logic       skipping;

  function automatic logic [1:0] chan_of(input logic [2:0] c);
    if (c[2] && !c[1]) return c[0] ? 2'b10 : 2'b01;
    return 2'b00;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end
  end

  assign scl_q     = scl_sy[1];
  assign sda_q     = sda_sy[1];
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;

  assign rbyte      = {2'b00, irq_i, ctrl_q};
  assign ch_en_o    = sel_q;
  assign sda_pull_o = pull;
  assign skipping   = (state == S_SKIP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= 3'd0;
      done   <= 1'b0;
      sh     <= 8'd0;
      tx     <= 7'd0;
      rw     <= 1'b0;
      nack   <= 1'b0;
      ctrl_q <= 4'd0;
      sel_q  <= 2'b00;
      pull   <= 1'b0;
    end else if (start_det) begin
      state <= S_ADDR;
      cnt   <= 3'd0;
      done  <= 1'b0;
      pull  <= 1'b0;
    end else if (stop_det) begin
      state <= S_IDLE;
      cnt   <= 3'd0;
      done  <= 1'b0;
      pull  <= 1'b0;
      sel_q <= chan_of(ctrl_q[2:0]);
    end else begin
      case (state)
        S_ADDR, S_WDAT: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_q};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) done <= 1'b1;
          end else if (scl_fall && done) begin
            done <= 1'b0;
            if (state == S_ADDR) begin
              if (sh[7:1] == {ADDR_PREFIX, strap_i}) begin
                pull  <= 1'b1;
                rw    <= sh[0];
                state <= S_AACK;
              end else begin
                state <= S_SKIP;
              end
            end else begin
              ctrl_q <= sh[3:0];
              pull   <= 1'b1;
              state  <= S_WACK;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            if (rw) begin
              tx    <= rbyte[6:0];
              pull  <= ~rbyte[7];
              state <= S_RDAT;
            end else begin
              pull  <= 1'b0;
              state <= S_WDAT;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            pull  <= 1'b0;
            state <= S_WDAT;
          end
        end
        S_RDAT: begin
          if (scl_rise) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) done <= 1'b1;
          end else if (scl_fall) begin
            if (done) begin
              done  <= 1'b0;
              pull  <= 1'b0;
              state <= S_RACK;
            end else begin
              pull <= ~tx[6];
              tx   <= {tx[5:0], 1'b0};
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            nack <= sda_q;
          end else if (scl_fall) begin
            if (nack) begin
              state <= S_SKIP;
            end else begin
              tx    <= rbyte[6:0];
              pull  <= ~rbyte[7];
              state <= S_RDAT;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/chan_mux_ctrl_chk.sv
module chan_mux_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ch_en,
  input logic       sda_pull,
  input logic       stop_seen,
  input logic       skipping,
  input logic [3:0] ctrl
);

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_en)); // R3

  AST_SEL_AT_STOP: assert property (@(posedge clk) disable iff (rst)
    !$stable(ch_en) |-> $past(stop_seen)); // R4

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (ch_en == 2'b00 && ctrl == 4'd0 && !sda_pull)); // R6

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
    skipping |-> !sda_pull); // R7

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_seen |=> !sda_pull); // R8

  AST_CTRL_AT_ACK: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl) |-> sda_pull); // R2

endmodule

bind chan_mux_ctrl chan_mux_ctrl_chk u_chk (
  .clk(clk),
  .rst(rst),
  .ch_en(ch_en_o),
  .sda_pull(sda_pull_o),
  .stop_seen(stop_det),
  .skipping(skipping),
  .ctrl(ctrl_q)
);

// File: tb/test_chan_mux_ctrl.sv
module test_chan_mux_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] AW = {4'b1110, STRAP, 1'b0};
  localparam logic [7:0] AR = {4'b1110, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] strap = STRAP;
  logic [1:0] irq = 2'b00;
  logic [1:0] ch_en;
  logic sda_pull;
  logic bus_sda;

  assign bus_sda = m_sda & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_mux_ctrl i_chan_mux_ctrl (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus_sda),
    .strap_i(strap), .irq_i(irq), .ch_en_o(ch_en), .sda_pull_o(sda_pull)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  task automatic expect_item(input string tag, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic observe(input logic [7:0] v);
    got_q.push_back(v);
  endtask

  always @(negedge clk) begin
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (g !== e) begin
        n_bad++;
        $display("FAIL %s got=%h exp=%h", t, g, e);
      end
    end
  end

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; qwait(Q);
    m_scl = 1'b1; qwait(2*Q);
    m_scl = 1'b0; qwait(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; qwait(Q);
    m_scl = 1'b1; qwait(Q);
    b = bus_sda; qwait(Q);
    m_scl = 1'b0; qwait(Q);
  endtask

  task automatic do_start;
    m_sda = 1'b1; qwait(Q);
    m_scl = 1'b1; qwait(Q);
    m_sda = 1'b0; qwait(Q);
    m_scl = 1'b0; qwait(Q);
  endtask

  task automatic do_stop;
    m_sda = 1'b0; qwait(Q);
    m_scl = 1'b1; qwait(Q);
    m_sda = 1'b1; qwait(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~mack);
  endtask

  task automatic check_ch(input string tag, input logic [1:0] e);
    expect_item(tag, {6'd0, e});
    observe({6'd0, ch_en});
  endtask

  task automatic write_reg(input logic [7:0] v, input string tag);
    logic ak;
    do_start;
    put_byte(AW, ak);
    expect_item({tag, " R1 addr ack"}, 8'd1); observe({7'd0, ak});
    put_byte(v, ak);
    expect_item({tag, " R2 data ack"}, 8'd1); observe({7'd0, ak});
    do_stop;
  endtask

  task automatic read_reg(input logic [7:0] e, input string tag);
    logic ak;
    logic [7:0] v;
    do_start;
    put_byte(AR, ak);
    expect_item({tag, " R1 read addr ack"}, 8'd1); observe({7'd0, ak});
    get_byte(v, 1'b0);
    expect_item(tag, e); observe(v);
    qwait(Q);
    expect_item({tag, " R8 line released after nack"}, 8'd1); observe({7'd0, bus_sda});
    do_stop;
  endtask

  initial begin
    logic ak;
    logic [7:0] v;
    qwait(5);
    rst = 1'b0;
    qwait(3);

    check_ch("R6 reset enables", 2'b00);
    read_reg(8'h00, "R6 reset readback");

    do_start;
    put_byte(AW, ak);
    expect_item("R1 addr ack", 8'd1); observe({7'd0, ak});
    put_byte(8'h04, ak);
    expect_item("R2 data ack", 8'd1); observe({7'd0, ak});
    qwait(Q);
    check_ch("R4 old selection before stop", 2'b00);
    do_stop;
    check_ch("R4 R3 channel 0 after stop", 2'b01);

    write_reg(8'h05, "w05");
    check_ch("R3 value 101 channel 1", 2'b10);
    write_reg(8'h06, "w06");
    check_ch("R3 value 110 none", 2'b00);
    write_reg(8'h04, "w04");
    write_reg(8'h07, "w07");
    check_ch("R3 value 111 none", 2'b00);
    write_reg(8'h05, "w05b");
    write_reg(8'h03, "w03");
    check_ch("R3 bit2 clear none", 2'b00);

    do_start;
    put_byte(AW, ak);
    expect_item("R2 multi addr ack", 8'd1); observe({7'd0, ak});
    put_byte(8'h04, ak);
    expect_item("R2 byte1 ack", 8'd1); observe({7'd0, ak});
    put_byte(8'h05, ak);
    expect_item("R2 byte2 ack", 8'd1); observe({7'd0, ak});
    put_byte(8'h0C, ak);
    expect_item("R2 byte3 ack", 8'd1); observe({7'd0, ak});
    do_stop;
    check_ch("R2 last byte selects channel 0", 2'b01);
    read_reg(8'h0C, "R2 last byte kept");

    write_reg(8'hFD, "wFD");
    check_ch("R3 channel 1 from FD", 2'b10);
    read_reg(8'h0D, "R5 upper bits read zero");
    irq = 2'b10;
    read_reg(8'h2D, "R5 irq1 in bit5");
    irq = 2'b01;
    read_reg(8'h1D, "R5 irq0 in bit4");
    irq = 2'b11;
    read_reg(8'h3D, "R5 both irq bits");

    irq = 2'b01;
    do_start;
    put_byte(AR, ak);
    expect_item("R5 two-byte read addr ack", 8'd1); observe({7'd0, ak});
    irq = 2'b10;
    get_byte(v, 1'b1);
    expect_item("R5 first byte captured at load", 8'h1D); observe(v);
    get_byte(v, 1'b0);
    expect_item("R5 second byte fresh status", 8'h2D); observe(v);
    do_stop;
    irq = 2'b00;

    strap = 3'b011;
    do_start;
    put_byte(AW, ak);
    expect_item("R7 strap mismatch no ack", 8'd0); observe({7'd0, ak});
    put_byte(8'h04, ak);
    expect_item("R7 data not acked", 8'd0); observe({7'd0, ak});
    do_stop;
    check_ch("R7 selection unchanged", 2'b10);
    do_start;
    put_byte(8'h50, ak);
    expect_item("R7 prefix mismatch no ack", 8'd0); observe({7'd0, ak});
    do_stop;
    strap = STRAP;
    read_reg(8'h0D, "R7 register unchanged");

    write_reg(8'h00, "w00");
    check_ch("R3 zero none", 2'b00);
    read_reg(8'h00, "R8 all-low byte");

    do_start;
    put_byte(AW, ak);
    expect_item("R9 first addr ack", 8'd1); observe({7'd0, ak});
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    do_start;
    put_byte(AW, ak);
    expect_item("R9 restart addr ack", 8'd1); observe({7'd0, ak});
    put_byte(8'h04, ak);
    expect_item("R9 data ack after restart", 8'd1); observe({7'd0, ak});
    do_stop;
    check_ch("R9 selection after restart", 2'b01);

    do_start;
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    do_start;
    put_byte(AR, ak);
    expect_item("R9 restart in address ack", 8'd1); observe({7'd0, ak});
    get_byte(v, 1'b0);
    expect_item("R9 partial byte discarded", 8'h04); observe(v);
    do_stop;

    qwait(10);
    if (exp_q.size() != 0 || got_q.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 scoreboard unbalanced got=%0d exp=%0d", got_q.size(), exp_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule